// File: doc/BRIEF.md
# Instruction Cycle Sequencing Controller

This controller walks a 32-bit processor through one instruction at a time. It holds the program counter and takes a snapshot of it at the start of every cycle. It screens the fetch address, first for word alignment and then for privilege. Only after both screens pass does it ask an external translation unit to map the address, and then it reads the instruction word. Once the word is in, it advances the counter by four and asks an external decoder whether the opcode is defined. It then hands the word to an external execute stage, waits for that stage to finish, and finally samples an admitted-interrupt flag.

Whenever something goes wrong, or an interrupt is taken, the controller records a cause code and raises a one-cycle vector request. With that request it presents a save value for general register 30 and, for fetch-time problems, a bad-address value. It then restarts fetching at a fixed service vector. The save value depends on the event. For exceptions it is the snapshot taken at the start of the cycle, so that the instruction runs again. For interrupts it is the counter value after execution, so that control resumes at the following instruction.

States and transitions: `ST_FETCH` (snapshot, address screens) goes to `ST_XLAT` on a clean address, or to `ST_TRAP` on a screen failure. `ST_XLAT` (translation handshake) goes to `ST_READ` on a clean response, or to `ST_TRAP` on a miss or an invalid entry. `ST_READ` (word read) goes to `ST_DECODE` on acknowledge. `ST_DECODE` (counter plus four, opcode check) goes to `ST_EXEC`, or to `ST_TRAP` on an undefined opcode. `ST_EXEC` goes to `ST_IRQ` on normal completion, or to `ST_TRAP` on a reported fault. `ST_IRQ` goes to `ST_TRAP` on an admitted interrupt, or otherwise back to `ST_FETCH`. `ST_TRAP` (vector request) always returns to `ST_FETCH`.

Top module: `instr_seq_ctrl`

## Requirements
- R1: After reset the counter equals `RESET_PC` (default 0x0000_1000), `vec_req` is low and `vec_cause` is 0. At most one of `xlat_req`, `mem_req`, `exec_go` and `vec_req` is high in any cycle.
- R2: A fetch address with either of bits 1..0 set produces cause 1 (misaligned). This takes priority over every other check, and no translation request is made.
- R3: An aligned address with bit 31 set, fetched while `user_mode` is 1, produces cause 2 (privileged) with no translation request. The same address fetched with `user_mode` 0 proceeds normally.
- R4: A translation response with `xlat_miss` set produces cause 3. This holds even when `xlat_inval` is also set. A response with only `xlat_inval` set produces cause 4.
- R5: Causes 1 to 4 assert `bad_we`, and `bad_addr` equals the faulting fetch address. All other causes leave `bad_we` low.
- R6: The counter grows by 4 once the word has been read. An undefined opcode (`opc_legal` 0) produces cause 5 and saves the address of that instruction, not the advanced value.
- R7: An execute-stage fault (`exec_fault` together with `exec_done`) produces cause 6 and saves the instruction's own address. This takes priority over an admitted interrupt in the same instruction.
- R8: An admitted interrupt sampled after a completed instruction produces cause 7 and saves the counter value after execution (address plus 4 when there is no jump).
- R9: Every vector request carries `save_we` with `save_idx` equal to 30. `save_we` is never active without `vec_req`, and register index 0 is never the save target.
- R10: `vec_req` lasts exactly one cycle, and the next fetch address is `VEC_ADDR` (default 0x0000_0100). `vec_cause` is 0 whenever `vec_req` is low.
- R11: A completed instruction with `exec_jump` set continues fetching at `exec_target` instead of address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | Processor is in user mode |
| fetch_addr | output | 32 | Current program counter / fetch address |
| xlat_req | output | 1 | Translation request for `fetch_addr` |
| xlat_ack | input | 1 | Translation response valid |
| xlat_miss | input | 1 | Response: no matching entry |
| xlat_inval | input | 1 | Response: matching entry not valid |
| mem_req | output | 1 | Instruction word read request |
| mem_ack | input | 1 | Instruction word valid |
| mem_rdata | input | 32 | Fetched instruction word |
| opc_legal | input | 1 | Decoder says the opcode is defined |
| exec_go | output | 1 | Execute stage may run the instruction |
| exec_instr | output | 32 | Instruction word held for execution |
| exec_done | input | 1 | Execute stage finished |
| exec_fault | input | 1 | Execute stage raised a fault |
| exec_jump | input | 1 | Execute stage redirects the counter |
| exec_target | input | 32 | Redirect address |
| irq_admit | input | 1 | Interrupt signalled and admitted |
| vec_req | output | 1 | One-cycle vector request |
| vec_cause | output | 3 | Cause code 0..7 |
| save_we | output | 1 | Write save value to general register |
| save_idx | output | 5 | Save register index (30) |
| save_pc | output | 32 | Value to save for return |
| bad_we | output | 1 | Write bad-address special register |
| bad_addr | output | 32 | Faulting fetch address |

## Verification
The hardest situations to reach from the ports are the ones that depend on the counter value, such as a misaligned or privileged fetch address. These come about only after the counter has been moved. The stimulus first runs one clean instruction whose execute stage reports a jump to the chosen address. It then applies the vector's responses just as the controller enters the fetch state, so each case starts from an exact address. Competing conditions are driven together so that the priority order decides the outcome: misaligned with privileged, miss with invalid, and fault with interrupt.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [2:0] {
        CS_NONE    = 3'd0,
        CS_ALIGN   = 3'd1,
        CS_PRIV    = 3'd2,
        CS_MISS    = 3'd3,
        CS_INVALID = 3'd4,
        CS_ILLEGAL = 3'd5,
        CS_EXEC    = 3'd6,
        CS_IRQ     = 3'd7
    } cause_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_XLAT   = 3'd1,
        ST_READ   = 3'd2,
        ST_DECODE = 3'd3,
        ST_EXEC   = 3'd4,
        ST_IRQ    = 3'd5,
        ST_TRAP   = 3'd6
    } seq_state_e;

    typedef struct packed {
        cause_e      cause;
        logic        bad;
        logic [31:0] save;
    } trap_rec_t;

endpackage

// File: rtl/isc_fetch_check.sv
module isc_fetch_check
    import isc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ALIGN_W  = 2,
    parameter int PRIV_BIT = 31
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              user_mode,
    input  logic              xlat_miss,
    input  logic              xlat_inval,
    output cause_e            addr_cause,
    output cause_e            xlat_cause
);

    logic misaligned;
    logic priv_hit;

    assign misaligned = |addr[ALIGN_W-1:0];
    assign priv_hit   = addr[PRIV_BIT] & user_mode;

    // Address screens: alignment first, privilege second.
    always_comb begin
        if (misaligned)
            addr_cause = CS_ALIGN;
        else if (priv_hit)
            addr_cause = CS_PRIV;
        else
            addr_cause = CS_NONE;
    end

    // Translation response: a miss outranks an invalid entry.
    always_comb begin
        if (xlat_miss)
            xlat_cause = CS_MISS;
        else if (xlat_inval)
            xlat_cause = CS_INVALID;
        else
            xlat_cause = CS_NONE;
    end

endmodule

// File: rtl/isc_pc_unit.sv
module isc_pc_unit #(
    parameter int          ADDR_W   = 32,
    parameter int          STEP     = 4,
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter logic [31:0] VEC_ADDR = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap,
    input  logic              step,
    input  logic              load_jump,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic              load_vec,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_snap
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= RESET_PC[ADDR_W-1:0];
            pc_snap <= RESET_PC[ADDR_W-1:0];
        end else begin
            if (snap)
                pc_snap <= pc;
            if (load_vec)
                pc <= VEC_ADDR[ADDR_W-1:0];
            else if (load_jump)
                pc <= jump_addr;
            else if (step)
                pc <= pc + STEP_V;
        end
    end

endmodule

// File: rtl/isc_seq_fsm.sv
module isc_seq_fsm
    import isc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] pc_snap,
    input  cause_e            addr_cause,
    input  cause_e            xlat_cause,
    input  logic              xlat_ack,
    input  logic              mem_ack,
    input  logic              opc_legal,
    input  logic              exec_done,
    input  logic              exec_fault,
    input  logic              exec_jump,
    input  logic              irq_admit,
    output logic              snap,
    output logic              step,
    output logic              load_jump,
    output logic              load_vec,
    output logic              ir_load,
    output logic              xlat_req,
    output logic              mem_req,
    output logic              exec_go,
    output logic              vec_req,
    output logic [2:0]        vec_cause,
    output logic              save_we,
    output logic [ADDR_W-1:0] save_pc,
    output logic              bad_we,
    output logic [ADDR_W-1:0] bad_addr
);

    seq_state_e state_q, state_d;
    trap_rec_t  rec_q, rec_d;
    logic       rec_set;

    // State register and trap record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            rec_q   <= '{cause: CS_NONE, bad: 1'b0, save: '0};
        end else begin
            state_q <= state_d;
            if (rec_set)
                rec_q <= rec_d;
        end
    end

    // Next state and the record to present in ST_TRAP
    always_comb begin
        state_d = state_q;
        rec_set = 1'b0;
        rec_d   = rec_q;
        unique case (state_q)
            ST_FETCH: begin
                if (addr_cause != CS_NONE) begin
                    rec_set = 1'b1;
                    rec_d   = '{cause: addr_cause, bad: 1'b1, save: 32'(pc)};
                    state_d = ST_TRAP;
                end else begin
                    state_d = ST_XLAT;
                end
            end
            ST_XLAT: begin
                if (xlat_ack) begin
                    if (xlat_cause != CS_NONE) begin
                        rec_set = 1'b1;
                        rec_d   = '{cause: xlat_cause, bad: 1'b1, save: 32'(pc_snap)};
                        state_d = ST_TRAP;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack)
                    state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (!opc_legal) begin
                    rec_set = 1'b1;
                    rec_d   = '{cause: CS_ILLEGAL, bad: 1'b0, save: 32'(pc_snap)};
                    state_d = ST_TRAP;
                end else begin
                    state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (exec_done) begin
                    if (exec_fault) begin
                        rec_set = 1'b1;
                        rec_d   = '{cause: CS_EXEC, bad: 1'b0, save: 32'(pc_snap)};
                        state_d = ST_TRAP;
                    end else begin
                        state_d = ST_IRQ;
                    end
                end
            end
            ST_IRQ: begin
                if (irq_admit) begin
                    rec_set = 1'b1;
                    rec_d   = '{cause: CS_IRQ, bad: 1'b0, save: 32'(pc)};
                    state_d = ST_TRAP;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_TRAP: state_d = ST_FETCH;
            default: state_d = ST_FETCH;
        endcase
    end

    // Outputs per state
    always_comb begin
        snap      = 1'b0;
        step      = 1'b0;
        load_jump = 1'b0;
        load_vec  = 1'b0;
        ir_load   = 1'b0;
        xlat_req  = 1'b0;
        mem_req   = 1'b0;
        exec_go   = 1'b0;
        vec_req   = 1'b0;
        vec_cause = 3'd0;
        save_we   = 1'b0;
        bad_we    = 1'b0;
        unique case (state_q)
            ST_FETCH:  snap = 1'b1;
            ST_XLAT:   xlat_req = 1'b1;
            ST_READ: begin
                mem_req = 1'b1;
                ir_load = mem_ack;
            end
            ST_DECODE: step = 1'b1;
            ST_EXEC: begin
                exec_go   = 1'b1;
                load_jump = exec_done & ~exec_fault & exec_jump;
            end
            ST_IRQ:    ;
            ST_TRAP: begin
                vec_req   = 1'b1;
                vec_cause = rec_q.cause;
                save_we   = 1'b1;
                bad_we    = rec_q.bad;
                load_vec  = 1'b1;
            end
            default:   ;
        endcase
    end

    assign save_pc  = rec_q.save[ADDR_W-1:0];
    assign bad_addr = rec_q.save[ADDR_W-1:0];

endmodule

// File: rtl/instr_seq_ctrl.sv
module instr_seq_ctrl
    import isc_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          WORD_W   = 32,
    parameter int          REG_AW   = 5,
    parameter int          SAVE_REG = 30,
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter logic [31:0] VEC_ADDR = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              xlat_req,
    input  logic              xlat_ack,
    input  logic              xlat_miss,
    input  logic              xlat_inval,
    output logic              mem_req,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              opc_legal,
    output logic              exec_go,
    output logic [WORD_W-1:0] exec_instr,
    input  logic              exec_done,
    input  logic              exec_fault,
    input  logic              exec_jump,
    input  logic [ADDR_W-1:0] exec_target,
    input  logic              irq_admit,
    output logic              vec_req,
    output logic [2:0]        vec_cause,
    output logic              save_we,
    output logic [REG_AW-1:0] save_idx,
    output logic [ADDR_W-1:0] save_pc,
    output logic              bad_we,
    output logic [ADDR_W-1:0] bad_addr
);

    localparam int ALIGN_W  = 2;
    localparam int STEP     = 1 << ALIGN_W;
    localparam int PRIV_BIT = ADDR_W - 1;

    logic [ADDR_W-1:0] pc, pc_snap;
    logic              snap, step, load_jump, load_vec, ir_load;
    cause_e            addr_cause, xlat_cause;
    logic [WORD_W-1:0] ir_q;

    generate
        if (SAVE_REG == 0 || SAVE_REG >= (1 << REG_AW)) begin : g_bad_save_reg
            initial $error("SAVE_REG must name a writable register");
        end
    endgenerate

    isc_fetch_check #(
        .ADDR_W  (ADDR_W),
        .ALIGN_W (ALIGN_W),
        .PRIV_BIT(PRIV_BIT)
    ) u_check (
        .addr      (pc),
        .user_mode (user_mode),
        .xlat_miss (xlat_miss),
        .xlat_inval(xlat_inval),
        .addr_cause(addr_cause),
        .xlat_cause(xlat_cause)
    );

    isc_pc_unit #(
        .ADDR_W  (ADDR_W),
        .STEP    (STEP),
        .RESET_PC(RESET_PC),
        .VEC_ADDR(VEC_ADDR)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap     (snap),
        .step     (step),
        .load_jump(load_jump),
        .jump_addr(exec_target),
        .load_vec (load_vec),
        .pc       (pc),
        .pc_snap  (pc_snap)
    );

    isc_seq_fsm #(
        .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc        (pc),
        .pc_snap   (pc_snap),
        .addr_cause(addr_cause),
        .xlat_cause(xlat_cause),
        .xlat_ack  (xlat_ack),
        .mem_ack   (mem_ack),
        .opc_legal (opc_legal),
        .exec_done (exec_done),
        .exec_fault(exec_fault),
        .exec_jump (exec_jump),
        .irq_admit (irq_admit),
        .snap      (snap),
        .step      (step),
        .load_jump (load_jump),
        .load_vec  (load_vec),
        .ir_load   (ir_load),
        .xlat_req  (xlat_req),
        .mem_req   (mem_req),
        .exec_go   (exec_go),
        .vec_req   (vec_req),
        .vec_cause (vec_cause),
        .save_we   (save_we),
        .save_pc   (save_pc),
        .bad_we    (bad_we),
        .bad_addr  (bad_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= '0;
        else if (ir_load)
            ir_q <= mem_rdata;
    end

    assign exec_instr = ir_q;
    assign fetch_addr = pc;
    assign save_idx   = REG_AW'(SAVE_REG);

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
    parameter int          ADDR_W   = 32,
    parameter int          REG_AW   = 5,
    parameter logic [31:0] VEC_ADDR = 32'h0000_0100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              xlat_req,
    input logic              mem_req,
    input logic              exec_go,
    input logic              vec_req,
    input logic [2:0]        vec_cause,
    input logic              save_we,
    input logic [REG_AW-1:0] save_idx,
    input logic [ADDR_W-1:0] save_pc,
    input logic              bad_we,
    input logic [ADDR_W-1:0] bad_addr
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xlat_req, mem_req, exec_go, vec_req})); // R1

    AST_XLAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req |-> (fetch_addr[1:0] == 2'b00)); // R2

    AST_BAD_FETCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_we |-> (vec_cause >= 3'd1 && vec_cause <= 3'd4)); // R5

    AST_BAD_IS_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        bad_we |-> (bad_addr == save_pc)); // R5

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exec_go) |-> (fetch_addr == $past(fetch_addr) + ADDR_W'(4))); // R6

    AST_SAVE_WITH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        save_we |-> (vec_req && save_idx != '0)); // R9

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req); // R10

    AST_VEC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> (fetch_addr == VEC_ADDR[ADDR_W-1:0])); // R10

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |-> (vec_cause == 3'd0)); // R10

    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (vec_cause != 3'd0)); // R10

endmodule

bind instr_seq_ctrl isc_checker #(
    .ADDR_W  (ADDR_W),
    .REG_AW  (REG_AW),
    .VEC_ADDR(VEC_ADDR)
) i_isc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_addr(fetch_addr),
    .xlat_req  (xlat_req),
    .mem_req   (mem_req),
    .exec_go   (exec_go),
    .vec_req   (vec_req),
    .vec_cause (vec_cause),
    .save_we   (save_we),
    .save_idx  (save_idx),
    .save_pc   (save_pc),
    .bad_we    (bad_we),
    .bad_addr  (bad_addr)
);

// File: tb/test_instr_seq_ctrl.sv
module test_instr_seq_ctrl;

    localparam logic [31:0] RESET_PC = 32'h0000_1000;
    localparam logic [31:0] VEC_ADDR = 32'h0000_0100;

    typedef struct packed {
        logic [31:0] tgt;
        logic        user;
        logic        miss;
        logic        inval;
        logic        opc;
        logic        fault;
        logic        irq;
        logic [2:0]  cause;
        logic [31:0] save;
        logic        bad;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TV [NV] = '{
        '{32'h8000_0001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 32'h8000_0001, 1'b1},
        '{32'h0000_0002, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 32'h0000_0002, 1'b1},
        '{32'h8000_0010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 32'h8000_0010, 1'b1},
        '{32'h8000_0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h8000_0014, 1'b0},
        '{32'h0000_3000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0000_3000, 1'b1},
        '{32'h0000_3004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 32'h0000_3004, 1'b1},
        '{32'h0000_3008, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0000_3008, 1'b1},
        '{32'h0000_3010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 32'h0000_3010, 1'b0},
        '{32'h0000_3014, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd6, 32'h0000_3014, 1'b0},
        '{32'h0000_3018, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd6, 32'h0000_3018, 1'b0},
        '{32'h0000_301C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd7, 32'h0000_3020, 1'b0},
        '{32'h0000_4000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0000_4004, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        user_mode, xlat_ack, xlat_miss, xlat_inval, mem_ack, opc_legal;
    logic        exec_done, exec_fault, exec_jump, irq_admit;
    logic [31:0] mem_rdata, exec_target;
    logic [31:0] fetch_addr, exec_instr, save_pc, bad_addr;
    logic        xlat_req, mem_req, exec_go, vec_req, save_we, bad_we;
    logic [2:0]  vec_cause;
    logic [4:0]  save_idx;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    instr_seq_ctrl #(.RESET_PC(RESET_PC), .VEC_ADDR(VEC_ADDR)) i_instr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .fetch_addr(fetch_addr),
        .xlat_req(xlat_req), .xlat_ack(xlat_ack), .xlat_miss(xlat_miss),
        .xlat_inval(xlat_inval), .mem_req(mem_req), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .opc_legal(opc_legal), .exec_go(exec_go),
        .exec_instr(exec_instr), .exec_done(exec_done), .exec_fault(exec_fault),
        .exec_jump(exec_jump), .exec_target(exec_target), .irq_admit(irq_admit),
        .vec_req(vec_req), .vec_cause(vec_cause), .save_we(save_we),
        .save_idx(save_idx), .save_pc(save_pc), .bad_we(bad_we), .bad_addr(bad_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5: return "R6";
            3'd6: return "R7";
            3'd7: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic clean_inputs();
        user_mode = 1'b0; xlat_ack = 1'b1; xlat_miss = 1'b0; xlat_inval = 1'b0;
        mem_ack = 1'b1; opc_legal = 1'b1; exec_done = 1'b1; exec_fault = 1'b0;
        exec_jump = 1'b0; irq_admit = 1'b0;
    endtask

    // Run one clean instruction that jumps to tgt (R11 path); return in ST_FETCH at tgt.
    task automatic steer(input logic [31:0] tgt);
        clean_inputs();
        exec_jump = 1'b1;
        exec_target = tgt;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (exec_go) break;
        end
        @(negedge clk);
        exec_jump = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        mem_rdata = 32'hA5A5_0001;
        exec_target = '0;
        clean_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset pc", fetch_addr, RESET_PC);
        chk("R1 reset vec_req", {31'd0, vec_req}, 32'd0);
        chk("R1 reset cause", {29'd0, vec_cause}, 32'd0);
        chk("R1 reset xlat_req", {31'd0, xlat_req}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic        saw_xlat, seen_go, got_vec, got_nxt;
            logic [31:0] nxt;
            logic [2:0]  c_cause;
            logic [31:0] c_save, c_bad;
            logic        c_bwe, c_swe;
            logic [4:0]  c_idx;
            saw_xlat = 0; seen_go = 0; got_vec = 0; got_nxt = 0;
            nxt = '0; c_cause = '0; c_save = '0; c_bad = '0; c_bwe = 0; c_swe = 0; c_idx = '0;
            steer(TV[v].tgt);
            mem_rdata = 32'hC0DE_0000 | v;
            user_mode = TV[v].user; xlat_miss = TV[v].miss; xlat_inval = TV[v].inval;
            opc_legal = TV[v].opc; exec_fault = TV[v].fault; irq_admit = TV[v].irq;
            for (int k = 0; k < 24; k++) begin
                @(negedge clk);
                if (vec_req) begin
                    got_vec = 1; c_cause = vec_cause; c_save = save_pc; c_bad = bad_addr;
                    c_bwe = bad_we; c_swe = save_we; c_idx = save_idx;
                    break;
                end
                if (exec_go) begin
                    seen_go = 1;
                    chk("R6 word to execute", exec_instr, 32'hC0DE_0000 | v);
                end
                if (xlat_req && !seen_go) saw_xlat = 1;
                if (xlat_req && seen_go) begin
                    got_nxt = 1; nxt = fetch_addr;
                    break;
                end
            end
            if (TV[v].cause == 3'd0) begin
                chk("R11 no vector", {31'd0, got_vec}, 32'd0);
                chk("R6 next fetch", nxt, TV[v].save);
                chk("R11 next fetch seen", {31'd0, got_nxt}, 32'd1);
            end else begin
                chk({tag_of(TV[v].cause), " cause"}, {29'd0, c_cause}, {29'd0, TV[v].cause});
                chk({tag_of(TV[v].cause), " save_pc"}, c_save, TV[v].save);
                chk("R5 bad_we", {31'd0, c_bwe}, {31'd0, TV[v].bad});
                if (TV[v].bad) chk("R5 bad_addr", c_bad, TV[v].tgt);
                chk("R9 save_we", {31'd0, c_swe}, 32'd1);
                chk("R9 save_idx", {27'd0, c_idx}, 32'd30);
                if (TV[v].cause <= 3'd2)
                    chk({tag_of(TV[v].cause), " no translation"}, {31'd0, saw_xlat}, 32'd0);
                @(negedge clk);
                chk("R10 pulse width", {31'd0, vec_req}, 32'd0);
                chk("R10 vector address", fetch_addr, VEC_ADDR);
                chk("R10 cause idle", {29'd0, vec_cause}, 32'd0);
            end
        end

        // Directed: jump then interrupt saves the jump target (R8, R11)
        steer(32'h0000_5000);
        clean_inputs();
        exec_jump = 1'b1; exec_target = 32'h0000_6000; irq_admit = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (vec_req) break;
        end
        chk("R8 irq after jump save", save_pc, 32'h0000_6000);
        chk("R11 irq after jump cause", {29'd0, vec_cause}, 32'd7);
        clean_inputs();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule